// File: doc/BRIEF.md
# Configuration Power-Up Sequencer

This block steps a programmable device from power-on to user mode. It first clears the configuration memory for a set minimum time. It then hands over to configuration loading, runs a three-step wake-up and finally enters user mode. Two shared open-drain lines coordinate the device with its neighbours. The ready line shows that clearing is under way, and any other device can hold it low to delay loading. The done line can likewise be held low by other devices to keep the device out of user mode until they are ready.

Each open-drain pin is split into two ports. One is an output that pulls the line low, and the other is an input that carries the level sampled on the wire. Every asynchronous input passes through a two-flop synchronizer before the state machine uses it. A cycle counter measures the minimum clearing time and stands in for the real memory clearing. Two status inputs from the data receiver report whether loading completed or failed. A mode selector picks which loading interface is active during configuration.

Top module: `cfg_powerup_seq`

## Requirements
- R1: While reset is asserted, the outputs are mem_clear_en=1, rdy_pull_low=1, done_pull_low=1, goe=0, gsr=1, gwd=1, cfg_done=0, user_mode=0 and cfg_if_sel=0. The clearing phase always shows exactly these values.
- R2: If reconfig_n is high and nothing holds the lines, mem_clear_en stays high for exactly INIT_CYCLES+1 cycles after reset is released. Clearing then ends, and the ready line is released (rdy_pull_low=0).
- R3: Clearing does not end while reconfig_n is low, however long the minimum time has been exceeded. Clearing ends once reconfig_n returns high.
- R4: After the ready line is released, loading does not begin while the ready line is held low externally. Loading begins within a few cycles of the line rising.
- R5: During loading, cfg_if_sel is one-hot with bit mode_sel set, using the mode_sel value captured when loading began. Later changes of mode_sel are ignored. Outside loading, cfg_if_sel is 0.
- R6: A data_err during loading moves the block to a fault phase. In the fault phase rdy_pull_low=1, done_pull_low=1, goe=0, gsr=1, gwd=1, cfg_done=0 and user_mode=0. data_ok is ignored there, and the fault phase lasts until a reconfigure request arrives.
- R7: A data_ok without data_err during loading gives wake step 1 in the next cycle: goe=1, gsr=1, gwd=1, cfg_done=1 and done_pull_low=1. If data_ok and data_err arrive together, the error wins.
- R8: Wake step 2 follows in the next cycle. It keeps goe=1, releases gsr and gwd to 0, and keeps done_pull_low=1.
- R9: Wake step 3 follows in the next cycle, with done_pull_low=0. User mode is not entered while the done line is held low externally. It is entered a few cycles after the line is seen high.
- R10: Once clearing has ended, a low reconfig_n in any phase returns the block to clearing, with the outputs of R1.
- R11: In user mode, user_mode=1, goe=1, cfg_done=1, and gsr, gwd, rdy_pull_low and done_pull_low are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| reconfig_n | input | 1 | Reconfigure request, active low, asynchronous |
| mode_sel | input | MODE_W | Loading interface selector |
| data_ok | input | 1 | All configuration data received correctly |
| data_err | input | 1 | Configuration data error |
| rdy_line_in | input | 1 | Sampled level of the ready line |
| rdy_pull_low | output | 1 | Pulls the ready line low |
| done_line_in | input | 1 | Sampled level of the done line |
| done_pull_low | output | 1 | Pulls the done line low |
| mem_clear_en | output | 1 | Memory clearing in progress |
| goe | output | 1 | Global output enable |
| gsr | output | 1 | Global set/reset |
| gwd | output | 1 | Global write disable |
| cfg_done | output | 1 | Internal done status |
| user_mode | output | 1 | Device in user mode |
| cfg_if_sel | output | 2**MODE_W | One-hot active loading interface |

## Verification
Several properties compare a state with reconfig_n as it was two cycles earlier. They therefore assume that reconfig_n, rdy_line_in and done_line_in change only between clock edges, so the two-flop synchronizer delay is a fixed two cycles. The bench drives every input at the falling edge. It builds each line level from the block's own pull-down output and an external hold, so the line can never read high while the block pulls it low. data_ok and data_err are assumed to be single-cycle pulses from the receiver, and the stimulus drives them that way. The one exception is a test that asserts both in the same cycle to exercise the error-first rule.

// File: rtl/cfg_powerup_seq.sv
module cfg_powerup_seq #(
  parameter int INIT_CYCLES = 16,
  parameter int MODE_W      = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     reconfig_n,
  input  logic [MODE_W-1:0]        mode_sel,
  input  logic                     data_ok,
  input  logic                     data_err,
  input  logic                     rdy_line_in,
  output logic                     rdy_pull_low,
  input  logic                     done_line_in,
  output logic                     done_pull_low,
  output logic                     mem_clear_en,
  output logic                     goe,
  output logic                     gsr,
  output logic                     gwd,
  output logic                     cfg_done,
  output logic                     user_mode,
  output logic [(1<<MODE_W)-1:0]   cfg_if_sel
);
  localparam int CNT_W = $clog2(INIT_CYCLES + 1);
  localparam int IF_N  = 1 << MODE_W;

  typedef enum logic [2:0] {
    S_CLEAR, S_RDYWAIT, S_LOAD, S_FAULT,
    S_WAKE_IO, S_WAKE_REL, S_WAKE_DONE, S_USER
  } st_t;

  st_t st, st_nx;
  logic [1:0] rdy_sy, done_sy, rc_sy;
  logic rdy_prev;
  logic [CNT_W-1:0] cnt;
  logic [MODE_W-1:0] mode_q;

  wire rdy_s   = rdy_sy[1];
  wire done_s  = done_sy[1];
  wire rc_s    = rc_sy[1];
  wire elapsed = (cnt == CNT_W'(INIT_CYCLES));
  wire rdy_rise = rdy_s & ~rdy_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_sy   <= '0;
      done_sy  <= '0;
      rc_sy    <= '0;
      rdy_prev <= 1'b0;
    end else begin
      rdy_sy   <= {rdy_sy[0], rdy_line_in};
      done_sy  <= {done_sy[0], done_line_in};
      rc_sy    <= {rc_sy[0], reconfig_n};
      rdy_prev <= rdy_s;
    end
  end

  always_comb begin
    st_nx = st;
    case (st)
      S_CLEAR:     if (elapsed && rc_s) st_nx = S_RDYWAIT;
      S_RDYWAIT:   if (rdy_rise) st_nx = S_LOAD;
      S_LOAD:      if (data_err) st_nx = S_FAULT;
                   else if (data_ok) st_nx = S_WAKE_IO;
      S_FAULT:     st_nx = S_FAULT;
      S_WAKE_IO:   st_nx = S_WAKE_REL;
      S_WAKE_REL:  st_nx = S_WAKE_DONE;
      S_WAKE_DONE: if (done_s) st_nx = S_USER;
      S_USER:      st_nx = S_USER;
      default:     st_nx = S_CLEAR;
    endcase
    if (st != S_CLEAR && !rc_s) st_nx = S_CLEAR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_CLEAR;
      cnt    <= '0;
      mode_q <= '0;
    end else begin
      st <= st_nx;
      if (st != S_CLEAR) cnt <= '0;
      else if (!elapsed) cnt <= cnt + 1'b1;
      if (st == S_RDYWAIT && st_nx == S_LOAD) mode_q <= mode_sel;
    end
  end

  wire awake   = (st == S_WAKE_IO) || (st == S_WAKE_REL) || (st == S_WAKE_DONE) || (st == S_USER);
  wire released = (st == S_WAKE_REL) || (st == S_WAKE_DONE) || (st == S_USER);

  assign mem_clear_en  = (st == S_CLEAR);
  assign rdy_pull_low  = (st == S_CLEAR) || (st == S_FAULT);
  assign done_pull_low = !((st == S_WAKE_DONE) || (st == S_USER));
  assign goe           = awake;
  assign cfg_done      = awake;
  assign gsr           = !released;
  assign gwd           = !released;
  assign user_mode     = (st == S_USER);
  assign cfg_if_sel    = (st == S_LOAD) ? (IF_N'(1) << mode_q) : '0;
endmodule

module cfg_powerup_seq_chk #(
  parameter int MODE_W = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reconfig_n,
  input logic                   data_err,
  input logic                   rdy_pull_low,
  input logic                   done_pull_low,
  input logic                   mem_clear_en,
  input logic                   goe,
  input logic                   gsr,
  input logic                   gwd,
  input logic                   user_mode,
  input logic [(1<<MODE_W)-1:0] cfg_if_sel
);
  AST_CLEAR_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n) mem_clear_en |-> rdy_pull_low && done_pull_low && !goe && gsr && gwd && !user_mode); // R1
  AST_RC_LOW_HOLDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) mem_clear_en && !$past(reconfig_n, 2) |=> mem_clear_en); // R3
  AST_IF_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(cfg_if_sel)); // R5
  AST_IF_STABLE: assert property (@(posedge clk) disable iff (!rst_n) (|cfg_if_sel) && $past(|cfg_if_sel) |-> $stable(cfg_if_sel)); // R5
  AST_ERR_TO_FAULT: assert property (@(posedge clk) disable iff (!rst_n) (|cfg_if_sel) && data_err |=> rdy_pull_low && !goe); // R6
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) rdy_pull_low && !mem_clear_en && $past(reconfig_n, 2) |=> rdy_pull_low && !mem_clear_en); // R6
  AST_GOE_UNDER_GSR: assert property (@(posedge clk) disable iff (!rst_n) $rose(goe) |-> gsr && gwd); // R7
  AST_GSR_AFTER_GOE: assert property (@(posedge clk) disable iff (!rst_n) $fell(gsr) |-> goe && $past(goe)); // R8
  AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n) $fell(done_pull_low) |-> !gsr && $past(!gsr)); // R9
  AST_USER_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(user_mode) |-> $past(!done_pull_low)); // R9
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n) !mem_clear_en && !$past(reconfig_n, 2) |=> mem_clear_en); // R10
  AST_USER_OUTPUTS: assert property (@(posedge clk) disable iff (!rst_n) user_mode |-> goe && !gsr && !gwd && !done_pull_low && !rdy_pull_low); // R11
endmodule

bind cfg_powerup_seq cfg_powerup_seq_chk #(.MODE_W(MODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reconfig_n(reconfig_n), .data_err(data_err),
  .rdy_pull_low(rdy_pull_low), .done_pull_low(done_pull_low),
  .mem_clear_en(mem_clear_en), .goe(goe), .gsr(gsr), .gwd(gwd),
  .user_mode(user_mode), .cfg_if_sel(cfg_if_sel)
);

// File: tb/sim_cfg_powerup_seq.sv
module sim_cfg_powerup_seq;
  localparam int N = 8;
  localparam int MW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reconfig_n = 1'b1;
  logic [MW-1:0] mode_sel = '0;
  logic data_ok = 1'b0, data_err = 1'b0;
  logic ext_rdy_hold = 1'b0, ext_done_hold = 1'b0;
  logic rdy_pull_low, done_pull_low, mem_clear_en, goe, gsr, gwd, cfg_done, user_mode;
  logic [(1<<MW)-1:0] cfg_if_sel;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  wire rdy_line  = !(rdy_pull_low || ext_rdy_hold);
  wire done_line = !(done_pull_low || ext_done_hold);
  wire [7:0] outs = {mem_clear_en, rdy_pull_low, done_pull_low, goe, gsr, gwd, cfg_done, user_mode};

  cfg_powerup_seq #(.INIT_CYCLES(N), .MODE_W(MW)) u0 (
    .clk(clk), .rst_n(rst_n), .reconfig_n(reconfig_n), .mode_sel(mode_sel),
    .data_ok(data_ok), .data_err(data_err), .rdy_line_in(rdy_line),
    .rdy_pull_low(rdy_pull_low), .done_line_in(done_line), .done_pull_low(done_pull_low),
    .mem_clear_en(mem_clear_en), .goe(goe), .gsr(gsr), .gwd(gwd),
    .cfg_done(cfg_done), .user_mode(user_mode), .cfg_if_sel(cfg_if_sel)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic       err;
    logic [3:0] rh;
    logic [3:0] dh;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{2'd0, 1'b0, 4'd0, 4'd0},
    '{2'd1, 1'b0, 4'd5, 4'd0},
    '{2'd2, 1'b0, 4'd0, 4'd7},
    '{2'd3, 1'b1, 4'd3, 4'd0},
    '{2'd3, 1'b0, 4'd9, 4'd4}
  };

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic rc);
    rst_n = 1'b0; mode_sel = m; reconfig_n = rc; data_ok = 1'b0; data_err = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {24'd0, outs}, 32'hEC);
    chk("R1 reset if_sel", {28'd0, cfg_if_sel}, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic wait_clear(output int n);
    n = 0;
    while (mem_clear_en && n < 300) begin @(negedge clk); n++; end
  endtask

  task automatic wait_load();
    for (int k = 0; k < 12 && cfg_if_sel == '0; k++) @(negedge clk);
  endtask

  task automatic wait_user();
    for (int k = 0; k < 12 && !user_mode; k++) @(negedge clk);
  endtask

  task automatic wait_mem();
    for (int k = 0; k < 12 && !mem_clear_en; k++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    int n;
    logic bad;
    foreach (VECS[i]) begin
      vec_t v = VECS[i];
      ext_rdy_hold  = (v.rh != 0);
      ext_done_hold = (v.dh != 0);
      do_reset(v.mode, 1'b1);
      wait_clear(n);
      chk("R2 clear length", n, N + 1);
      chk("R2 ready released", {24'd0, outs}, 32'h2C);
      if (v.rh != 0) begin
        bad = 1'b0;
        for (int j = 0; j < int'(v.rh); j++) begin
          @(negedge clk);
          if (cfg_if_sel != '0) bad = 1'b1;
        end
        chk("R4 load blocked by ready hold", {31'd0, bad}, 32'd0);
        ext_rdy_hold = 1'b0;
      end
      wait_load();
      chk("R4 R5 loading interface", {28'd0, cfg_if_sel}, 32'd1 << v.mode);
      if (v.err) begin
        data_err = 1'b1; @(negedge clk); data_err = 1'b0;
        chk("R6 fault outputs", {24'd0, outs}, 32'h6C);
        chk("R6 fault if_sel", {28'd0, cfg_if_sel}, 32'd0);
        data_ok = 1'b1; repeat (3) @(negedge clk); data_ok = 1'b0; @(negedge clk);
        chk("R6 data_ok ignored in fault", {24'd0, outs}, 32'h6C);
      end else begin
        data_ok = 1'b1; @(negedge clk); data_ok = 1'b0;
        chk("R7 wake step 1", {24'd0, outs}, 32'h3E);
        @(negedge clk);
        chk("R8 wake step 2", {24'd0, outs}, 32'h32);
        @(negedge clk);
        chk("R9 wake step 3", {24'd0, outs}, 32'h12);
        if (v.dh != 0) begin
          bad = 1'b0;
          for (int j = 0; j < int'(v.dh); j++) begin
            @(negedge clk);
            if (user_mode) bad = 1'b1;
          end
          chk("R9 user blocked by done hold", {31'd0, bad}, 32'd0);
          ext_done_hold = 1'b0;
        end
        wait_user();
        chk("R11 user outputs", {24'd0, outs}, 32'h13);
      end
    end

    ext_rdy_hold = 1'b0; ext_done_hold = 1'b0;
    do_reset(2'd0, 1'b0);
    repeat (3 * N) @(negedge clk);
    chk("R3 clear held by reconfig", {31'd0, mem_clear_en}, 32'd1);
    reconfig_n = 1'b1;
    wait_clear(n);
    chk("R3 clear ends after reconfig high", {31'd0, mem_clear_en}, 32'd0);

    do_reset(2'd1, 1'b1);
    wait_clear(n);
    wait_load();
    mode_sel = 2'd2;
    repeat (3) @(negedge clk);
    chk("R5 mode change ignored", {28'd0, cfg_if_sel}, 32'd2);
    data_ok = 1'b1; data_err = 1'b1; @(negedge clk);
    data_ok = 1'b0; data_err = 1'b0;
    chk("R7 error wins over ok", {24'd0, outs}, 32'h6C);
    reconfig_n = 1'b0;
    wait_mem();
    chk("R10 restart from fault", {24'd0, outs}, 32'hEC);
    reconfig_n = 1'b1;
    wait_clear(n);
    chk("R10 clearing completes again", {24'd0, outs}, 32'h2C);

    do_reset(2'd3, 1'b1);
    wait_clear(n);
    wait_load();
    data_ok = 1'b1; @(negedge clk); data_ok = 1'b0;
    wait_user();
    chk("R11 user reached", {24'd0, outs}, 32'h13);
    reconfig_n = 1'b0;
    wait_mem();
    chk("R10 restart from user", {24'd0, outs}, 32'hEC);
    chk("R10 restart if_sel", {28'd0, cfg_if_sel}, 32'd0);
    reconfig_n = 1'b1;
    report();
  end
endmodule